// File: doc/BRIEF.md
# Dual-Protocol Host Bus Slave Interface

This block is the slave side of a host processor bus. It accepts two styles of bus cycle. In the first style, one data strobe is paired with a read/not-write level. In the second style, the reads and writes each have their own strobe. Address and data share one multiplexed bus. An address strobe latches the register index at the start of a cycle. A qualified strobe then reads or writes one of eight registers in a small internal register file. All bus inputs pass through a single register stage clocked by the system clock. Every output therefore reflects the input sample taken at the preceding rising clock edge.

A handshake output serves both host families. Its meaning is fixed by a mode pin, which is sampled when register 0 (the configuration register) is written for the first time after reset. In ready/wait use, the output only holds off an interrupt acknowledge that is not ready to complete. In acknowledge use, the output confirms register accesses and ready interrupt acknowledges. Interrupt acknowledge arrives on two inputs: a level-style status input that turns a data or read strobe into an acknowledge cycle, and a pulse-style input that is a strobe on its own. A readiness input tells the block when such a cycle may complete.

Top module: `hbi_dual_slave`

## Requirements
- R1: The read/not-write level `rnw` (1 = read, 0 = write) is taken at the clock sample where `data_stb_n` is first seen low. Changes to `rnw` later in the same strobe do not alter the direction of the cycle.
- R2: A data-strobe or read-strobe cycle is a register access only when `sel_n` is low and `iack_lvl_n` is high. If `iack_lvl_n` is low, that cycle is an interrupt acknowledge instead. A write-strobe cycle is a register write only when `sel_n` is low. In all other cases the register file is left unchanged.
- R3: A register write stores the value on `bus_in` from the last sample in which the strobe was low. The store takes effect once the strobe has been seen high again.
- R4: During a qualified register read, `bus_oe` is 1 and `bus_out` carries the addressed register. At all other times `bus_oe` is 0 and `bus_out` is all zeros.
- R5: If more than one of `data_stb_n`, `rd_stb_n`, `wr_stb_n` and `iack_pls_n` is low in a sample, the whole cycle is void until all four are high again. A void cycle writes nothing, does not drive the bus and leaves `hshk_n` high.
- R6: Out of reset the handshake is in ready/wait use. The first completed write to register 0 samples `hs_sel`: 1 selects ready/wait use and 0 selects acknowledge use. The new use applies from the next sample onward.
- R7: In ready/wait use, `hshk_n` is 0 only while an interrupt acknowledge is in progress and `iack_ready` is 0. It stays 1 during register reads and writes.
- R8: In acknowledge use, `hshk_n` is 0 during every qualified register read or write, and during an interrupt acknowledge while `iack_ready` is 1. It is 1 otherwise.
- R9: After the first write to register 0, later writes to register 0 still store data but leave the handshake use unchanged until reset.
- R10: `hshk_n` is always driven to a defined 0 or 1.
- R11: The register index is `bus_in[2:0]`, latched at the sample where `addr_stb_n` is first seen low. Each of the eight registers holds its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_stb_n | input | 1 | Address strobe; its falling edge latches the register index |
| sel_n | input | 1 | Chip select, active low |
| data_stb_n | input | 1 | Data strobe, used with `rnw` |
| rnw | input | 1 | 1 = read, 0 = write, for data-strobe cycles |
| rd_stb_n | input | 1 | Read strobe, active low |
| wr_stb_n | input | 1 | Write strobe, active low |
| iack_lvl_n | input | 1 | Level-style interrupt acknowledge status, active low |
| iack_pls_n | input | 1 | Pulse-style interrupt acknowledge strobe, active low |
| hs_sel | input | 1 | Handshake use select, sampled at the first write to register 0 |
| iack_ready | input | 1 | Interrupt acknowledge may complete |
| bus_in | input | 16 | Multiplexed address/data bus, incoming |
| bus_out | output | 16 | Read data, all zeros when not driving |
| bus_oe | output | 1 | Output enable for the bus pad driver |
| hshk_n | output | 1 | Wait or acknowledge handshake, active low |

## Verification
Two events can fall on the same clock edge: the commit of a write to register 0, and the locking of the handshake use. The very next sample must already follow the new use. The bench provokes this by starting a read immediately after the first configuration write. It also repeats configuration writes with the opposite `hs_sel` level, to show that the data is stored while the use stays locked. A behavioural model in the bench computes the expected `hshk_n`, `bus_oe` and `bus_out` for every clock and compares them in every cycle, in both strobe styles and both handshake uses.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef struct packed {
        logic addr_stb_n;
        logic sel_n;
        logic data_stb_n;
        logic rnw;
        logic rd_stb_n;
        logic wr_stb_n;
        logic iack_lvl_n;
        logic iack_pls_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{
        addr_stb_n: 1'b1, sel_n: 1'b1, data_stb_n: 1'b1, rnw: 1'b1,
        rd_stb_n: 1'b1, wr_stb_n: 1'b1, iack_lvl_n: 1'b1, iack_pls_n: 1'b1
    };

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_REG_RD = 2'd1,
        ACC_REG_WR = 2'd2,
        ACC_IACK   = 2'd3
    } acc_e;

    typedef enum logic {
        HS_ACK  = 1'b0,
        HS_WAIT = 1'b1
    } hs_mode_e;

    // number of cycle-starting strobes currently low
    function automatic logic [2:0] strobes_low(ctl_t c);
        int n;
        n = 0;
        if (!c.data_stb_n) n++;
        if (!c.rd_stb_n)   n++;
        if (!c.wr_stb_n)   n++;
        if (!c.iack_pls_n) n++;
        return 3'(n);
    endfunction

endpackage

// File: rtl/hbi_sampler.sv
module hbi_sampler
    import hbi_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl_in,
    input  logic [DW-1:0] bus_in,
    input  logic          hs_sel_in,
    input  logic          rdy_in,
    output ctl_t          cur,
    output logic          prv_ds_n,
    output logic          prv_as_n,
    output logic [DW-1:0] bus_q,
    output logic          hs_sel_q,
    output logic          rdy_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= CTL_IDLE;
            prv_ds_n <= 1'b1;
            prv_as_n <= 1'b1;
            bus_q    <= '0;
            hs_sel_q <= 1'b1;
            rdy_q    <= 1'b0;
        end else begin
            cur      <= ctl_in;
            prv_ds_n <= cur.data_stb_n;
            prv_as_n <= cur.addr_stb_n;
            bus_q    <= bus_in;
            hs_sel_q <= hs_sel_in;
            rdy_q    <= rdy_in;
        end
    end

endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
    import hbi_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          cur,
    input  logic          prv_ds_n,
    input  logic          prv_as_n,
    input  logic [DW-1:0] bus_q,
    output acc_e          acc,
    output logic          overlap,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] rd_addr
);

    logic [2:0]    nlow;
    logic          idle;
    logic          single;
    logic          ds_fall;
    logic          as_fall;
    logic          rw_eff;
    logic          rw_q;
    logic          bad_q;
    logic          pend_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] paddr_q;
    logic [DW-1:0] pdata_q;

    assign nlow    = strobes_low(cur);
    assign idle    = (nlow == 3'd0);
    assign overlap = (nlow > 3'd1);
    assign single  = (nlow == 3'd1) && !bad_q;
    assign ds_fall = prv_ds_n && !cur.data_stb_n;
    assign as_fall = prv_as_n && !cur.addr_stb_n;
    assign rw_eff  = ds_fall ? cur.rnw : rw_q;

    always_comb begin
        acc = ACC_NONE;
        if (single) begin
            if (!cur.iack_pls_n) begin
                acc = ACC_IACK;
            end else if (!cur.wr_stb_n) begin
                if (!cur.sel_n) acc = ACC_REG_WR;
            end else if (!cur.iack_lvl_n) begin
                acc = ACC_IACK;
            end else if (!cur.sel_n) begin
                acc = (!cur.rd_stb_n || rw_eff) ? ACC_REG_RD : ACC_REG_WR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rw_q    <= 1'b1;
            bad_q   <= 1'b0;
            addr_q  <= '0;
            pend_q  <= 1'b0;
            paddr_q <= '0;
            pdata_q <= '0;
        end else begin
            if (ds_fall) rw_q <= cur.rnw;
            if (as_fall) addr_q <= bus_q[AW-1:0];
            if (overlap)   bad_q <= 1'b1;
            else if (idle) bad_q <= 1'b0;
            if (overlap) begin
                pend_q <= 1'b0;
            end else if (acc == ACC_REG_WR) begin
                pend_q  <= 1'b1;
                paddr_q <= addr_q;
                pdata_q <= bus_q;
            end else if (idle) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign wr_en   = pend_q && idle;
    assign wr_addr = paddr_q;
    assign wr_data = pdata_q;
    assign rd_addr = addr_q;

    AST_RW_HELD: assert property (@(posedge clk) disable iff (rst)
        (!cur.data_stb_n && !prv_ds_n) |=> $stable(rw_q)); // R1

    AST_WR_AFTER_TRAIL: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(idle)); // R3

    AST_OVERLAP_NO_WR: assert property (@(posedge clk) disable iff (rst)
        overlap |=> !wr_en); // R5

endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile #(
    parameter int DW    = 16,
    parameter int AW    = 3,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (wr_en && (wr_addr == AW'(i))) begin
                mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data))); // R3

endmodule

// File: rtl/hbi_handshake.sv
module hbi_handshake
    import hbi_pkg::*;
#(
    parameter int AW       = 3,
    parameter int CFG_ADDR = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_e          acc,
    input  logic          hs_sel_q,
    input  logic          rdy_q,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    output hs_mode_e      mode,
    output logic          hshk_n
);

    hs_mode_e mode_q;
    logic     locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= HS_WAIT;
            locked_q <= 1'b0;
        end else if (wr_en && (wr_addr == AW'(CFG_ADDR)) && !locked_q) begin
            mode_q   <= hs_mode_e'(hs_sel_q);
            locked_q <= 1'b1;
        end
    end

    always_comb begin
        if (mode_q == HS_WAIT) begin
            hshk_n = !((acc == ACC_IACK) && !rdy_q);
        end else begin
            hshk_n = !((acc == ACC_REG_RD) || (acc == ACC_REG_WR) ||
                       ((acc == ACC_IACK) && rdy_q));
        end
    end

    assign mode = mode_q;

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> (locked_q && $stable(mode_q))); // R9

    AST_HS_DEFINED: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(hshk_n)); // R10

endmodule

// File: rtl/hbi_dual_slave.sv
module hbi_dual_slave
    import hbi_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 3,
    parameter int CFG_ADDR = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_stb_n,
    input  logic          sel_n,
    input  logic          data_stb_n,
    input  logic          rnw,
    input  logic          rd_stb_n,
    input  logic          wr_stb_n,
    input  logic          iack_lvl_n,
    input  logic          iack_pls_n,
    input  logic          hs_sel,
    input  logic          iack_ready,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          hshk_n
);

    localparam int DEPTH = 1 << AW;

    ctl_t          ctl_in;
    ctl_t          cur;
    logic          prv_ds_n;
    logic          prv_as_n;
    logic [DW-1:0] bus_q;
    logic          hs_sel_q;
    logic          rdy_q;
    acc_e          acc;
    logic          overlap;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    hs_mode_e      mode;

    assign ctl_in = '{
        addr_stb_n: addr_stb_n, sel_n: sel_n, data_stb_n: data_stb_n,
        rnw: rnw, rd_stb_n: rd_stb_n, wr_stb_n: wr_stb_n,
        iack_lvl_n: iack_lvl_n, iack_pls_n: iack_pls_n
    };

    hbi_sampler #(.DW(DW)) u_sampler (
        .clk(clk), .rst(rst), .ctl_in(ctl_in), .bus_in(bus_in),
        .hs_sel_in(hs_sel), .rdy_in(iack_ready),
        .cur(cur), .prv_ds_n(prv_ds_n), .prv_as_n(prv_as_n),
        .bus_q(bus_q), .hs_sel_q(hs_sel_q), .rdy_q(rdy_q)
    );

    hbi_decode #(.DW(DW), .AW(AW)) u_decode (
        .clk(clk), .rst(rst), .cur(cur), .prv_ds_n(prv_ds_n),
        .prv_as_n(prv_as_n), .bus_q(bus_q), .acc(acc), .overlap(overlap),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
    );

    hbi_regfile #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    hbi_handshake #(.AW(AW), .CFG_ADDR(CFG_ADDR)) u_handshake (
        .clk(clk), .rst(rst), .acc(acc), .hs_sel_q(hs_sel_q), .rdy_q(rdy_q),
        .wr_en(wr_en), .wr_addr(wr_addr), .mode(mode), .hshk_n(hshk_n)
    );

    assign bus_oe  = (acc == ACC_REG_RD);
    assign bus_out = bus_oe ? rd_data : '0;

    AST_OVERLAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        overlap |-> (hshk_n && !bus_oe)); // R5

    AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !$past(sel_n)); // R2

    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_out == '0)); // R4

    AST_WAIT_NO_REG_HS: assert property (@(posedge clk) disable iff (rst)
        ((mode == HS_WAIT) && (acc inside {ACC_REG_RD, ACC_REG_WR})) |-> hshk_n); // R7

endmodule

// File: tb/hbi_dual_slave_tb.sv
`timescale 1ns/1ps
module hbi_dual_slave_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_stb_n = 1'b1, sel_n = 1'b1, data_stb_n = 1'b1, rnw = 1'b1;
    logic        rd_stb_n = 1'b1, wr_stb_n = 1'b1, iack_lvl_n = 1'b1, iack_pls_n = 1'b1;
    logic        hs_sel = 1'b1, iack_ready = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic        hshk_n;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // behavioural reference state
    logic [15:0] m_mem [8];
    int          m_addr;
    bit          m_rw, m_bad, m_pend, m_wait, m_locked, m_prev_ds, m_prev_as;
    int          m_paddr;
    logic [15:0] m_pdata;

    always #4 clk = ~clk;

    hbi_dual_slave u_dut (
        .clk(clk), .rst(rst), .addr_stb_n(addr_stb_n), .sel_n(sel_n),
        .data_stb_n(data_stb_n), .rnw(rnw), .rd_stb_n(rd_stb_n),
        .wr_stb_n(wr_stb_n), .iack_lvl_n(iack_lvl_n), .iack_pls_n(iack_pls_n),
        .hs_sel(hs_sel), .iack_ready(iack_ready), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .hshk_n(hshk_n)
    );

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_mem[i] = '0;
        m_addr = 0; m_rw = 1; m_bad = 0; m_pend = 0; m_wait = 1; m_locked = 0;
        m_prev_ds = 1; m_prev_as = 1; m_paddr = 0; m_pdata = '0;
    endtask

    task automatic do_reset();
        addr_stb_n = 1; sel_n = 1; data_stb_n = 1; rnw = 1; rd_stb_n = 1;
        wr_stb_n = 1; iack_lvl_n = 1; iack_pls_n = 1; iack_ready = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    // one clock: predict, advance, compare, update the model
    task automatic tick(string tag);
        int nlow;
        bit dsfall, rweff, single, e_rd, e_wr, e_ia, e_hs;
        logic [15:0] e_bus;
        nlow = int'(!data_stb_n) + int'(!rd_stb_n) + int'(!wr_stb_n) + int'(!iack_pls_n);
        dsfall = m_prev_ds && !data_stb_n;
        rweff  = dsfall ? rnw : m_rw;
        single = (nlow == 1) && !m_bad;
        e_rd = single && !sel_n && iack_lvl_n && iack_pls_n && (!rd_stb_n || (!data_stb_n && rweff));
        e_wr = single && !sel_n && (!wr_stb_n || (!data_stb_n && iack_lvl_n && !rweff));
        e_ia = single && (!iack_pls_n || (!iack_lvl_n && (!data_stb_n || !rd_stb_n)));
        e_hs = m_wait ? !(e_ia && !iack_ready) : !(e_rd || e_wr || (e_ia && iack_ready));
        e_bus = e_rd ? m_mem[m_addr] : 16'h0;

        @(posedge clk);
        @(negedge clk);
        vectors++;
        if ($isunknown(hshk_n)) begin
            fails++;
            $display("FAIL R10 hshk_n undefined: actual %b expected %b", hshk_n, e_hs);
        end else if (hshk_n !== e_hs || bus_oe !== e_rd || bus_out !== e_bus) begin
            fails++;
            $display("FAIL %s at %0t: actual hs=%b oe=%b bus=%h expected hs=%b oe=%b bus=%h",
                     tag, $time, hshk_n, bus_oe, bus_out, e_hs, e_rd, e_bus);
        end

        if (nlow > 1) begin
            m_pend = 0;
        end else if (e_wr) begin
            m_pend = 1; m_paddr = m_addr; m_pdata = bus_in;
        end else if (nlow == 0) begin
            if (m_pend) begin
                m_mem[m_paddr] = m_pdata;
                if (m_paddr == 0 && !m_locked) begin
                    m_wait = hs_sel; m_locked = 1;
                end
            end
            m_pend = 0;
        end
        if (nlow > 1) m_bad = 1; else if (nlow == 0) m_bad = 0;
        if (m_prev_as && !addr_stb_n) m_addr = int'(bus_in[2:0]);
        if (dsfall) m_rw = rnw;
        m_prev_ds = data_stb_n;
        m_prev_as = addr_stb_n;
    endtask

    task automatic addr_phase(int a, string tag);
        bus_in = 16'(a); addr_stb_n = 0; tick(tag);
        addr_stb_n = 1; tick(tag);
    endtask

    // data strobe with read/not-write level
    task automatic ds_cycle(int a, bit rd, logic [15:0] d, bit sel, string tag);
        addr_phase(a, "R11");
        sel_n = sel; rnw = rd; bus_in = d; data_stb_n = 0; tick(tag);
        tick(tag);
        data_stb_n = 1; tick(tag);
        sel_n = 1; tick(tag);
    endtask

    // separate read and write strobes
    task automatic split_cycle(int a, bit rd, logic [15:0] d, bit sel, string tag);
        addr_phase(a, "R11");
        sel_n = sel; bus_in = d;
        if (rd) rd_stb_n = 0; else wr_stb_n = 0;
        tick(tag); tick(tag);
        rd_stb_n = 1; wr_stb_n = 1; tick(tag);
        sel_n = 1; tick(tag);
    endtask

    task automatic iack_cycle(bit pulse, bit rdy, string tag);
        iack_ready = rdy;
        if (pulse) iack_pls_n = 0;
        else begin iack_lvl_n = 0; data_stb_n = 0; end
        tick(tag); tick(tag);
        iack_pls_n = 1; iack_lvl_n = 1; data_stb_n = 1; iack_ready = 0;
        tick(tag);
    endtask

    task automatic mode_pass(bit wait_use);
        string hs_tag;
        hs_tag = wait_use ? "R7" : "R8";
        // first configuration write and an immediate read: lock and use together
        hs_sel = wait_use;
        ds_cycle(0, 0, 16'h0C0F ^ 16'(wait_use), 0, "R6");
        ds_cycle(0, 1, 16'h0, 0, "R6");
        // opposite pin on a later configuration write has no effect on the use
        hs_sel = !wait_use;
        split_cycle(0, 0, 16'h5A00, 0, "R9");
        split_cycle(0, 1, 16'h0, 0, "R9");
        ds_cycle(3, 1, 16'h0, 0, "R9");
        // every register, both styles, crossed
        for (int a = 0; a < 8; a++) begin
            ds_cycle(a, 0, 16'h1357 + 16'(a * 16'h0111) + 16'(wait_use), 0, "R3");
            ds_cycle(a, 1, 16'h0, 0, hs_tag);
            split_cycle(a, 1, 16'h0, 0, "R4");
            split_cycle(a, 0, 16'hE000 - 16'(a * 16'h0203), 0, "R3");
            split_cycle(a, 1, 16'h0, 0, hs_tag);
            ds_cycle(a, 1, 16'h0, 0, "R11");
        end
        // direction fixed at the strobe's falling sample
        addr_phase(5, "R11");
        sel_n = 0; rnw = 1; data_stb_n = 0; tick("R1");
        rnw = 0; bus_in = 16'hDEAD; tick("R1"); tick("R1");
        data_stb_n = 1; tick("R1"); sel_n = 1; rnw = 1; tick("R1");
        ds_cycle(5, 1, 16'h0, 0, "R1");
        // unselected and acknowledge-qualified strobes leave registers alone
        ds_cycle(6, 0, 16'hBAD1, 1, "R2");
        iack_lvl_n = 0; split_cycle(6, 0, 16'hBAD2, 1, "R2"); iack_lvl_n = 1;
        iack_lvl_n = 0; ds_cycle(6, 0, 16'hBAD3, 0, "R2"); iack_lvl_n = 1;
        split_cycle(6, 1, 16'h0, 0, "R2");
        // overlapping strobes void the cycle
        addr_phase(2, "R11");
        sel_n = 0; rnw = 0; bus_in = 16'hF00D; data_stb_n = 0; wr_stb_n = 0; tick("R5");
        wr_stb_n = 1; tick("R5"); tick("R5");
        data_stb_n = 1; tick("R5"); sel_n = 1; tick("R5");
        ds_cycle(2, 1, 16'h0, 0, "R5");
        // interrupt acknowledge in both readiness states, both styles
        iack_cycle(1, 0, hs_tag);
        iack_cycle(1, 1, hs_tag);
        iack_cycle(0, 0, hs_tag);
        iack_cycle(0, 1, hs_tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        tick("R6");          // reset state: ready/wait use, bus released
        tick("R4");
        mode_pass(1'b0);     // acknowledge use
        do_reset();
        tick("R6");
        mode_pass(1'b1);     // ready/wait use
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule